// File: doc/BRIEF.md
# Serial Codec Input Frame Receiver

This block sits on the controller side of a serial codec link and turns the codec-to-controller bit stream into parallel slot words. It runs on the link bit clock, sees the frame marker that the controller itself drives, and samples the codec data line on the falling clock edge. Each frame opens with a 16-bit header slot, followed by twelve 20-bit payload slots. The first header bit says whether the codec is ready. The next twelve header bits mark, in order, which payload slots carry valid data.

Each payload slot whose header mark is set, in a frame whose ready bit is set, is delivered as one 20-bit word together with its slot number and a single-cycle strobe. A frame whose ready bit is clear delivers nothing. A filtered readiness output lets upstream logic hold off until the codec has reported ready for two frames in a row. Payload slot 12 carries modem line status, and the block decodes it into two per-line status vectors and a status-change flag.

A frame marker that arrives before the current frame is complete ends that frame at once. The receiver then aligns to the new frame.

Top module: `acl_in_deframer`

## Requirements
- R1: After a synchronous reset, `slot_stb` is 0, `codec_ready` is 0, and `line1_stat`, `line2_stat` and `gpio_chg` are 0.
- R2: A frame begins at a rising edge of `sync`. `sdata_in` is sampled on falling edges of `bclk`. Header bit 15 is the value the codec drives after the first rising edge of `bclk` that follows the falling edge on which `sync` is first seen high.
- R3: Bits arrive most significant first: 16 header bits, then payload slots 1 to 12 of 20 bits each. `slot_word` holds the slot's first received bit in bit 19.
- R4: Payload slot n is strobed when header bit (15 - n) is 1 and header bit 15 is 1. `slot_stb` is high for exactly one cycle, together with `slot_id` = n and `slot_word`, and it becomes visible after the (17 + 20n)th rising edge of `bclk` that follows the edge on which `sync` was raised.
- R5: In a frame whose header bit 15 is 0, no slot is strobed, whatever the other header bits are.
- R6: A payload slot whose header mark is 0 produces no strobe.
- R7: `codec_ready` rises only after header bit 15 has been 1 in two consecutive frames. One ready frame on its own leaves it at 0.
- R8: `codec_ready` falls to 0 within the first three `bclk` cycles of any frame whose header bit 15 is 0.
- R9: A rising edge of `sync` before the last bit of slot 12 abandons the current frame. The slot being assembled is not delivered, and the new frame's slots follow the timing of R4.
- R10: On a strobe of slot 12 the status outputs load from the slot word. `line2_stat[5:0]` takes word bits 19..14, `line1_stat[5:0]` takes word bits 9..4, `line2_stat[6]` takes bit 2, `line1_stat[6]` takes bit 1, and `gpio_chg` takes bit 0. Each status vector is laid out {frame detect, pin B, pin A, loop-current change, caller-ID path, ring, off hook}. Without such a strobe, the status outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Link bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame marker driven by the controller |
| sdata_in | input | 1 | Serial data from the codec |
| slot_stb | output | 1 | One-cycle strobe for a valid payload slot |
| slot_id | output | 4 | Number of the strobed slot, 1 to 12 |
| slot_word | output | 20 | Payload of the strobed slot |
| codec_ready | output | 1 | Filtered codec readiness |
| line1_stat | output | 7 | Decoded status of modem line 1 |
| line2_stat | output | 7 | Decoded status of modem line 2 |
| gpio_chg | output | 1 | Status-change flag from slot 12 |

## Verification
A wrong bit or slot position shows at the ports as a strobe in the wrong cycle or as a word shifted by one bit. The bench catches this on the first valid slot, 37 cycles after the frame marker rises. A tag or ready flag held in the wrong state shows within one frame, either as an extra strobe or as a missing one. A readiness filter or an early-marker recovery that has drifted from its rules shows at the next header bit or at the next slot boundary after the disturbance.

// File: rtl/acl_in_pkg.sv
package acl_in_pkg;
    localparam int HDR_BITS  = 16;
    localparam int WORD_BITS = 20;
    localparam int SLOT_CNT  = 12;
    localparam int SLOT_W    = $clog2(SLOT_CNT + 1);
    localparam int POS_W     = $clog2(WORD_BITS);

    // slot 12 field positions
    localparam int L2_LSB = 14;
    localparam int L1_LSB = 4;
    localparam int L2_FD  = 2;
    localparam int L1_FD  = 1;
    localparam int CHG_B  = 0;

    typedef struct packed {
        logic fdt;
        logic pin_b;
        logic pin_a;
        logic loop_delta;
        logic cid;
        logic ring;
        logic off_hook;
    } line_stat_t;

    typedef struct packed {
        logic              live;
        logic [SLOT_W-1:0] slot;
        logic [POS_W-1:0]  pos;
        logic              last;
        logic              abort;
    } bit_ctx_t;

    function automatic line_stat_t unpack_line(input logic [5:0] f, input logic fd);
        line_stat_t s;
        s.fdt        = fd;
        s.pin_b      = f[5];
        s.pin_a      = f[4];
        s.loop_delta = f[3];
        s.cid        = f[2];
        s.ring       = f[1];
        s.off_hook   = f[0];
        return s;
    endfunction
endpackage

// File: rtl/acl_edge_sampler.sv
module acl_edge_sampler (
    input  logic clk,
    input  logic rst,
    input  logic sync,
    input  logic sdata,
    output logic sd_s,
    output logic sync_rise
);
    logic sync_s, sync_d;

    // capture half a period after the codec launches its data
    always_ff @(negedge clk) begin
        if (rst) begin
            sd_s   <= 1'b0;
            sync_s <= 1'b0;
        end else begin
            sd_s   <= sdata;
            sync_s <= sync;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sync_d <= 1'b0;
        else     sync_d <= sync_s;
    end

    assign sync_rise = sync_s & ~sync_d;
endmodule

// File: rtl/acl_frame_timer.sv
module acl_frame_timer
    import acl_in_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_rise,
    output bit_ctx_t ctx
);
    logic              live_q;
    logic [SLOT_W-1:0] slot_q;
    logic [POS_W-1:0]  pos_q;
    logic              last, frame_end;

    always_comb begin
        last      = (slot_q == '0) ? (pos_q == POS_W'(HDR_BITS - 1))
                                   : (pos_q == POS_W'(WORD_BITS - 1));
        frame_end = live_q && last && (slot_q == SLOT_W'(SLOT_CNT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            slot_q <= '0;
            pos_q  <= '0;
        end else if (sync_rise) begin
            live_q <= 1'b1;
            slot_q <= '0;
            pos_q  <= '0;
        end else if (live_q) begin
            if (last) begin
                pos_q <= '0;
                if (slot_q == SLOT_W'(SLOT_CNT)) begin
                    live_q <= 1'b0;
                    slot_q <= '0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    always_comb begin
        ctx.live  = live_q;
        ctx.slot  = slot_q;
        ctx.pos   = pos_q;
        ctx.last  = last;
        ctx.abort = sync_rise && live_q && !frame_end;
    end

    // R9: an early marker realigns the counters to the first header bit
    p_abort_realign_r9: assert property (@(posedge clk) disable iff (rst)
        ctx.abort |=> (live_q && slot_q == '0 && pos_q == '0));
endmodule

// File: rtl/acl_slot0_track.sv
module acl_slot0_track
    import acl_in_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sd,
    input  bit_ctx_t            ctx,
    output logic                frame_ok,
    output logic [SLOT_CNT:1]   tags,
    output logic                codec_ready
);
    logic hdr, first_bit, seen_prev;

    assign hdr       = ctx.live && !ctx.abort && (ctx.slot == '0);
    assign first_bit = hdr && (ctx.pos == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_ok    <= 1'b0;
            tags        <= '0;
            seen_prev   <= 1'b0;
            codec_ready <= 1'b0;
        end else if (first_bit) begin
            frame_ok    <= sd;
            tags        <= '0;
            seen_prev   <= sd;
            codec_ready <= sd & seen_prev;
        end else if (hdr) begin
            for (int k = 1; k <= SLOT_CNT; k++) begin
                if (ctx.pos == POS_W'(k)) tags[k] <= sd & frame_ok;
            end
        end
    end

    // R7: readiness rises only on the second ready frame in a row
    p_ready_two_frames_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(codec_ready) |-> ($past(seen_prev) && frame_ok));
    // R8: a not-ready header bit drops readiness on the next edge
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (first_bit && !sd) |=> !codec_ready);
endmodule

// File: rtl/acl_slot_shift.sv
module acl_slot_shift
    import acl_in_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sd,
    input  bit_ctx_t              ctx,
    input  logic                  frame_ok,
    input  logic [SLOT_CNT:1]     tags,
    output logic                  stb,
    output logic [SLOT_W-1:0]     id,
    output logic [WORD_BITS-1:0]  word,
    output line_stat_t            line1,
    output line_stat_t            line2,
    output logic                  chg
);
    logic [WORD_BITS-2:0] shreg;
    logic [WORD_BITS-1:0] word_now;
    logic                 payload, tag_hit;

    assign payload  = ctx.live && !ctx.abort && (ctx.slot != '0);
    assign word_now = {shreg, sd};

    always_comb begin
        tag_hit = 1'b0;
        for (int k = 1; k <= SLOT_CNT; k++) begin
            if (ctx.slot == SLOT_W'(k)) tag_hit = tags[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            stb   <= 1'b0;
            id    <= '0;
            word  <= '0;
            line1 <= '0;
            line2 <= '0;
            chg   <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (payload) begin
                shreg <= word_now[WORD_BITS-2:0];
                if (ctx.last && tag_hit) begin
                    stb  <= 1'b1;
                    id   <= ctx.slot;
                    word <= word_now;
                    if (ctx.slot == SLOT_W'(SLOT_CNT)) begin
                        line2 <= unpack_line(word_now[L2_LSB +: 6], word_now[L2_FD]);
                        line1 <= unpack_line(word_now[L1_LSB +: 6], word_now[L1_FD]);
                        chg   <= word_now[CHG_B];
                    end
                end
            end
        end
    end

    // R4: strobes are single cycles naming a payload slot
    p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);
    p_stb_id_range_r4: assert property (@(posedge clk) disable iff (rst)
        stb |-> (id >= SLOT_W'(1) && id <= SLOT_W'(SLOT_CNT)));
    // R5: nothing is delivered from a frame that was not ready
    p_stb_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
        stb |-> frame_ok);
    // R10: status holds unless slot 12 is strobed
    p_status_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(stb && id == SLOT_W'(SLOT_CNT)) |-> ($stable(line1) && $stable(line2) && $stable(chg)));
endmodule

// File: rtl/acl_in_deframer.sv
module acl_in_deframer
    import acl_in_pkg::*;
(
    input  logic        bclk,
    input  logic        rst,
    input  logic        sync,
    input  logic        sdata_in,
    output logic        slot_stb,
    output logic [3:0]  slot_id,
    output logic [19:0] slot_word,
    output logic        codec_ready,
    output logic [6:0]  line1_stat,
    output logic [6:0]  line2_stat,
    output logic        gpio_chg
);
    logic                  sd_s, sync_rise, frame_ok;
    logic [SLOT_CNT:1]     tags;
    bit_ctx_t              ctx;
    line_stat_t            l1, l2;
    logic [SLOT_W-1:0]     id_w;
    logic [WORD_BITS-1:0]  word_w;

    acl_edge_sampler u_smp (
        .clk(bclk), .rst(rst), .sync(sync), .sdata(sdata_in),
        .sd_s(sd_s), .sync_rise(sync_rise)
    );

    acl_frame_timer u_tmr (
        .clk(bclk), .rst(rst), .sync_rise(sync_rise), .ctx(ctx)
    );

    acl_slot0_track u_hdr (
        .clk(bclk), .rst(rst), .sd(sd_s), .ctx(ctx),
        .frame_ok(frame_ok), .tags(tags), .codec_ready(codec_ready)
    );

    acl_slot_shift u_shf (
        .clk(bclk), .rst(rst), .sd(sd_s), .ctx(ctx),
        .frame_ok(frame_ok), .tags(tags),
        .stb(slot_stb), .id(id_w), .word(word_w),
        .line1(l1), .line2(l2), .chg(gpio_chg)
    );

    assign slot_id    = id_w;
    assign slot_word  = word_w;
    assign line1_stat = l1;
    assign line2_stat = l2;
endmodule

// File: tb/acl_in_deframer_bench.sv
`timescale 1ns/1ps
module acl_in_deframer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync = 1'b0;
    logic        sdata_in = 1'b0;
    logic        slot_stb;
    logic [3:0]  slot_id;
    logic [19:0] slot_word;
    logic        codec_ready;
    logic [6:0]  line1_stat, line2_stat;
    logic        gpio_chg;

    always #4 clk = ~clk;

    acl_in_deframer u_acl_in_deframer (
        .bclk(clk), .rst(rst), .sync(sync), .sdata_in(sdata_in),
        .slot_stb(slot_stb), .slot_id(slot_id), .slot_word(slot_word),
        .codec_ready(codec_ready), .line1_stat(line1_stat),
        .line2_stat(line2_stat), .gpio_chg(gpio_chg)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int cnt  [16] = '{default: 0};
    int scyc [16] = '{default: 0};
    logic [19:0] got [16] = '{default: '0};
    int total_stb = 0;
    logic carry = 1'b0;
    int f0 = 0;
    logic [255:0] fa, fb;

    // strobe monitor, away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst && slot_stb) begin
            cnt[slot_id]  <= cnt[slot_id] + 1;
            got[slot_id]  <= slot_word;
            scyc[slot_id] <= cyc;
            total_stb     <= total_stb + 1;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [19:0] mkword(input int s, input int k);
        return 20'((s * 40503 + k * 2654435) ^ (k << 7) ^ (s << 11));
    endfunction

    function automatic logic [19:0] slotw(input logic [255:0] f, input int k);
        return f[255 - 16 - 20 * (k - 1) -: 20];
    endfunction

    function automatic logic [255:0] mk_frame(input logic rdy, input logic [11:0] tg, input int seed);
        logic [255:0] f;
        f[255 -: 16] = {rdy, tg, 3'b000};
        for (int k = 1; k <= 12; k++) f[255 - 16 - 20 * (k - 1) -: 20] = mkword(seed, k);
        return f;
    endfunction

    // codec side: marker raised at c=0, header bit 15 launched at c=1
    task automatic drive_frame(input logic [255:0] f, input int len);
        for (int c = 0; c < len; c++) begin
            @(posedge clk); #1;
            if (c == 0) f0 = cyc;
            sync     = (c < 16);
            sdata_in = (c == 0) ? carry : f[255 - (c - 1)];
        end
        carry = f[255 - (len - 1)];
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #1;
            sync     = 1'b0;
            sdata_in = (c == 0) ? carry : 1'b0;
        end
        carry = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 strobe", slot_stb, 0);
        chk("R1 ready", codec_ready, 0);
        chk("R1 status", {line1_stat, line2_stat, gpio_chg}, 0);
    endtask

    task automatic t_basic;
        int b [16];
        int fa0, fb0;
        b = cnt;
        fa = mk_frame(1'b1, 12'hFFF, 1);
        fb = mk_frame(1'b1, 12'b001000000001, 2);
        drive_frame(fa, 256); fa0 = f0;
        drive_frame(fb, 256); fb0 = f0;
        idle(6);
        chk("R2 R4 slot1 timing", scyc[1] - fa0, 37);
        chk("R4 slot12 timing", scyc[12] - fb0, 257);
        chk("R3 slot1 word", got[1], slotw(fa, 1));
        chk("R3 slot7 word", got[7], slotw(fa, 7));
        chk("R4 slot3 word", got[3], slotw(fb, 3));
        chk("R6 slot2 untagged", cnt[2] - b[2], 1);
        chk("R4 slot3 count", cnt[3] - b[3], 2);
        chk("R7 ready after two", codec_ready, 1);
        chk("R10 line2", line2_stat, {slotw(fb, 12)[2], slotw(fb, 12)[19:14]});
        chk("R10 line1", line1_stat, {slotw(fb, 12)[1], slotw(fb, 12)[9:4]});
        chk("R10 chg", gpio_chg, slotw(fb, 12)[0]);
    endtask

    task automatic t_not_ready;
        logic [255:0] fz, fc;
        int tot;
        logic [6:0] l1, l2;
        l1 = line1_stat; l2 = line2_stat;
        fz = mk_frame(1'b0, 12'hFFF, 9);
        drive_frame(fz, 8);
        chk("R8 immediate drop", codec_ready, 0);
        tot = total_stb;
        drive_frame(fz, 256);
        idle(6);
        chk("R5 no strobes", total_stb - tot, 0);
        chk("R10 held", {line1_stat, line2_stat}, {l1, l2});
        fc = mk_frame(1'b1, 12'hFFE, 3);
        drive_frame(fc, 256);
        idle(6);
        chk("R7 single frame not enough", codec_ready, 0);
        chk("R6 R10 slot12 untagged", {line1_stat, line2_stat}, {l1, l2});
        chk("R6 slot11 delivered", got[11], slotw(fc, 11));
    endtask

    task automatic t_early;
        logic [255:0] fp, fq;
        int b [16];
        int q0;
        b = cnt;
        fp = mk_frame(1'b1, 12'hFFF, 5);
        fq = mk_frame(1'b1, 12'hFFF, 6);
        drive_frame(fp, 100);
        drive_frame(fq, 256); q0 = f0;
        idle(6);
        chk("R9 slot4 both", cnt[4] - b[4], 2);
        chk("R9 slot5 once", cnt[5] - b[5], 1);
        chk("R9 slot5 word", got[5], slotw(fq, 5));
        chk("R9 slot5 timing", scyc[5] - q0, 117);
        chk("R7 ready again", codec_ready, 1);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung, expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_not_ready();
        t_early();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule